// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiply-Add

This block computes the fused unsigned expression a·x + y for W-bit operands and returns a 2W-bit result. The partial products are formed with AND gates, one row per multiplier bit, and are accumulated by a one-sided chain of carry-save rows rather than a tree. The top row would normally see a zero operand. Here the addend y takes that place, so the addition costs no extra adder.

A register bank follows every carry-save row. Each bank carries the multiplicand, the multiplier, the running sum and carry vectors, and the product bits already retired. A final registered W-bit carry-propagate adder merges the sum and carry vectors into the upper half of the result. The unit accepts a new operation on every clock. The input side has a valid strobe only, with no ready. The output side also has a valid strobe only. There is no back-pressure: the consumer must take each result in the one cycle in which `out_valid` is high.

Top module: `array_fma_pipe`

## Requirements
- R1: For every operation accepted (in_valid high at a rising clock edge), out_result equals in_a·in_x + in_y as an unsigned 2W-bit number.
- R2: An operation sampled at rising edge n is presented with out_valid high after rising edge n+W−1 and until edge n+W. That makes W register stages: W−1 carry-save rows and one carry-propagate stage.
- R3: Operations may arrive on every consecutive clock with no gap. Results leave in the order of entry, one per clock. There is no ready signal and no back-pressure.
- R4: With in_x = 0 or in_a = 0 the result equals in_y. With in_y = 0 the result equals the plain product.
- R5: With all three operands at all-ones the result is 2^(2W) − 2^W. No result ever exceeds that value.
- R6: A cycle with in_valid low yields a cycle with out_valid low W cycles later. In that cycle out_result keeps the last delivered value, or 0 if nothing has been delivered since reset.
- R7: rst_n is asynchronous and active low. It discards every operation in flight. While rst_n is low and until a new operation has passed through, out_valid is low and out_result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on in_a, in_x, in_y are to be processed |
| in_a | input | W | Multiplicand, unsigned |
| in_x | input | W | Multiplier, unsigned |
| in_y | input | W | Addend, unsigned |
| out_valid | output | 1 | out_result holds a new result this cycle |
| out_result | output | 2W | a·x + y of the operation leaving the pipe |

## Verification
The interesting collision is a result retiring through the carry-propagate stage in the same cycle that a fresh operand set enters the first carry-save row. Every row in between also holds a different operation. A continuous stream of every operand combination keeps this overlap present on every clock. Each output is judged against a·x + y computed in the bench and delayed by exactly W cycles.

Bubbles interleaved with operations make a held output coincide with a new operation entering. There the bench checks that out_result does not move. A reset issued while operations are in flight checks that none of them emerges.

// File: rtl/afp_pkg.sv
package afp_pkg;
  // full-adder sum and carry, used bitwise by the carry-save rows
  function automatic logic fa_sum(input logic p, input logic q, input logic r);
    return p ^ q ^ r;
  endfunction

  function automatic logic fa_cy(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction
endpackage

// File: rtl/afp_ppgen.sv
module afp_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0] mcand,
  input  logic         mbit,
  output logic [W-1:0] pp
);
  // one AND gate per multiplicand bit
  assign pp = mcand & {W{mbit}};
endmodule

// File: rtl/afp_csa_row.sv
module afp_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] s_in,   // sum vector, base weight b
  input  logic [W-1:0] c_in,   // carry vector, base weight b
  input  logic [W-1:0] pp,     // partial product, base weight b+1
  output logic [W-1:0] s_out,  // sum vector, base weight b+1
  output logic [W-1:0] c_out,  // carry vector, base weight b+1
  output logic         p_bit   // retired product bit at weight b
);
  import afp_pkg::*;

  logic [W:0]   t_sum;
  logic [W-1:0] t_cy;  // t_cy[i] has weight b+i+1

  // lowest column: no partial-product bit, half adder
  assign t_sum[0] = s_in[0] ^ c_in[0];
  assign t_cy[0]  = s_in[0] & c_in[0];

  for (genvar i = 1; i < W; i++) begin : g_col
    assign t_sum[i] = fa_sum(s_in[i], c_in[i], pp[i-1]);
    assign t_cy[i]  = fa_cy(s_in[i], c_in[i], pp[i-1]);
  end

  // top column holds only the partial product's high bit
  assign t_sum[W] = pp[W-1];

  assign p_bit = t_sum[0];
  assign s_out = t_sum[W:1];
  assign c_out = t_cy;
endmodule

// File: rtl/afp_stage.sv
module afp_stage #(
  parameter int W   = 8,
  parameter int IDX = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic [W-2:0] lo_in,
  output logic         v_q,
  output logic [W-1:0] a_q,
  output logic [W-1:0] x_q,
  output logic [W-1:0] s_q,
  output logic [W-1:0] c_q,
  output logic [W-2:0] lo_q
);
  localparam int LOW = W - 1;

  logic [W-1:0]   pp;
  logic [W-1:0]   s_nx;
  logic [W-1:0]   c_nx;
  logic           p_bit;
  logic [LOW-1:0] lo_nx;

  afp_ppgen #(.W(W)) u_pp (
    .mcand (a_in),
    .mbit  (x_in[IDX]),
    .pp    (pp)
  );

  afp_csa_row #(.W(W)) u_row (
    .s_in  (s_in),
    .c_in  (c_in),
    .pp    (pp),
    .s_out (s_nx),
    .c_out (c_nx),
    .p_bit (p_bit)
  );

  always_comb begin
    lo_nx          = lo_in;
    lo_nx[IDX-1]   = p_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      a_q  <= '0;
      x_q  <= '0;
      s_q  <= '0;
      c_q  <= '0;
      lo_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        a_q  <= a_in;
        x_q  <= x_in;
        s_q  <= s_nx;
        c_q  <= c_nx;
        lo_q <= lo_nx;
      end
    end
  end

  // R1: the row conserves value: in_sum + in_carry + 2*pp == retired bit + 2*(out_sum + out_carry)
  assert_row_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |-> (({2'b00, s_in} + {2'b00, c_in} + {1'b0, pp, 1'b0}) ==
              {({1'b0, s_nx} + {1'b0, c_nx}), p_bit}));
endmodule

// File: rtl/afp_cpa.sv
module afp_cpa #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_in,
  input  logic [W-1:0]   s_in,
  input  logic [W-1:0]   c_in,
  input  logic [W-2:0]   lo_in,
  output logic           v_q,
  output logic [2*W-1:0] res_q
);
  localparam int RW = 2 * W;
  localparam logic [RW-1:0] MAXV = {{W{1'b1}}, {W{1'b0}}};

  logic [W:0]    upper;
  logic [RW-1:0] res_nx;

  assign upper  = {1'b0, s_in} + {1'b0, c_in};
  assign res_nx = {upper, lo_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      res_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) res_q <= res_nx;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> (res_q <= MAXV));

  assert_bubble_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> $stable(res_q));
endmodule

// File: rtl/array_fma_pipe.sv
module array_fma_pipe #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_x,
  input  logic [W-1:0]   in_y,
  output logic           out_valid,
  output logic [2*W-1:0] out_result
);
  localparam int NROW = W - 1;  // carry-save rows after the addend-fed top

  logic         st_v  [0:NROW];
  logic [W-1:0] st_a  [0:NROW];
  logic [W-1:0] st_x  [0:NROW];
  logic [W-1:0] st_s  [0:NROW];
  logic [W-1:0] st_c  [0:NROW];
  logic [W-2:0] st_lo [0:NROW];
  logic [W-1:0] pp0;

  // top of the array: addend takes the slot of the zero operand
  afp_ppgen #(.W(W)) u_pp0 (
    .mcand (in_a),
    .mbit  (in_x[0]),
    .pp    (pp0)
  );

  assign st_v[0]  = in_valid;
  assign st_a[0]  = in_a;
  assign st_x[0]  = in_x;
  assign st_s[0]  = in_y;
  assign st_c[0]  = pp0;
  assign st_lo[0] = '0;

  for (genvar j = 1; j <= NROW; j++) begin : g_row
    afp_stage #(.W(W), .IDX(j)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (st_v[j-1]),
      .a_in  (st_a[j-1]),
      .x_in  (st_x[j-1]),
      .s_in  (st_s[j-1]),
      .c_in  (st_c[j-1]),
      .lo_in (st_lo[j-1]),
      .v_q   (st_v[j]),
      .a_q   (st_a[j]),
      .x_q   (st_x[j]),
      .s_q   (st_s[j]),
      .c_q   (st_c[j]),
      .lo_q  (st_lo[j])
    );
  end

  afp_cpa #(.W(W)) u_cpa (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (st_v[NROW]),
    .s_in  (st_s[NROW]),
    .c_in  (st_c[NROW]),
    .lo_in (st_lo[NROW]),
    .v_q   (out_valid),
    .res_q (out_result)
  );

  // R7: a clock seen in reset leaves no result behind it
  assert_reset_flush_R7: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && (out_result == '0)));
endmodule

// File: tb/array_fma_pipe_tb_top.sv
module array_fma_pipe_tb_top;
  localparam int W   = 4;
  localparam int LAT = W;
  localparam int RW  = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_x = '0;
  logic [W-1:0]  in_y = '0;
  logic          out_valid;
  logic [RW-1:0] out_result;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string vtag = "R2";

  logic          m_v [0:LAT-1];
  logic [RW-1:0] m_r [0:LAT-1];
  string         m_t [0:LAT-1];
  logic [RW-1:0] last_r = '0;

  always #2 clk = ~clk;

  array_fma_pipe #(.W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_x       (in_x),
    .in_y       (in_y),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < LAT; i++) begin
      m_v[i] = 1'b0; m_r[i] = '0; m_t[i] = "R1";
    end
    last_r = '0;
  endtask

  function automatic string classify(input logic [W-1:0] a, input logic [W-1:0] x, input logic [W-1:0] y);
    if (a == '1 && x == '1 && y == '1) return "R5";
    if (a == '0 || x == '0 || y == '0) return "R4";
    return "R1";
  endfunction

  task automatic observe();
    chk(vtag, "out_valid", 64'(out_valid), 64'(m_v[LAT-1]));
    if (m_v[LAT-1]) begin
      chk(m_t[LAT-1], "out_result", 64'(out_result), 64'(m_r[LAT-1]));
      last_r = m_r[LAT-1];
    end else begin
      chk("R6", "held out_result", 64'(out_result), 64'(last_r));
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    observe();
    in_valid = v; in_a = a; in_x = x; in_y = y;
    for (int i = LAT - 1; i > 0; i--) begin
      m_v[i] = m_v[i-1]; m_r[i] = m_r[i-1]; m_t[i] = m_t[i-1];
    end
    m_v[0] = v;
    m_r[0] = {{W{1'b0}}, a} * {{W{1'b0}}, x} + {{W{1'b0}}, y};
    m_t[0] = classify(a, x, y);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    clear_model();
    // R7: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R7", "out_valid in reset", 64'(out_valid), 64'd0);
      chk("R7", "out_result in reset", 64'(out_result), 64'd0);
    end
    rst_n = 1'b1;

    // R3 + R1/R4/R5: every operand combination, back to back
    vtag = "R3";
    for (int a = 0; a < (1 << W); a++)
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          step(1'b1, W'(a), W'(x), W'(y));

    // R6: bubbles between operations
    vtag = "R6";
    for (int i = 0; i < 96; i++)
      step((i % 3) != 0, W'(i * 7 + 3), W'(i * 5 + 1), W'(i * 3));
    repeat (LAT + 2) step(1'b0, '1, '1, '1);

    // R2: single isolated operation, exact latency
    vtag = "R2";
    step(1'b1, W'(9), W'(11), W'(6));
    repeat (LAT + 2) step(1'b0, '0, '0, '0);

    // R7: reset with operations in flight
    step(1'b1, '1, '1, '1);
    step(1'b1, W'(5), W'(6), W'(7));
    @(negedge clk);
    observe();
    rst_n = 1'b0;
    in_valid = 1'b0;
    clear_model();
    repeat (2) begin
      @(negedge clk);
      chk("R7", "out_valid during reset", 64'(out_valid), 64'd0);
      chk("R7", "out_result during reset", 64'(out_result), 64'd0);
    end
    rst_n = 1'b1;
    vtag = "R7";
    repeat (LAT + 1) step(1'b0, '0, '0, '0);

    // resume after reset
    vtag = "R2";
    step(1'b1, W'(12), W'(13), W'(1));
    step(1'b1, '1, '1, '1);
    step(1'b1, W'(3), '0, W'(10));
    repeat (LAT + 1) step(1'b0, '0, '0, '0);

    summary();
  end
endmodule